// File: doc/BRIEF.md
# Three-Wire Serial Memory Slave

This block models the serial side of a small nonvolatile memory reached over a three-wire select/clock/data bus. A system clock oversamples chip select, serial clock and serial data, so every piece of logic runs in one clock domain. While selected, the block waits for a logic-1 start bit. It then collects a two-bit opcode and an address field, decodes one of seven instructions and either streams stored words out on a data-out line or prepares a programming command.

Read data comes from an internal register array. The array resets to the erased value (all ones). Programming commands (write word, erase word, write all, erase all) are issued as a one-cycle decoded pulse to an external timing sequencer. The same pulse updates the array. The sequencer returns a busy flag, and the block reports it as a ready/busy level on data-out on the next selection. Data-out comes with a separate enable, so a pad can tri-state it. A static input picks 16-bit words (512 of them) or 8-bit words (1024 of them).

Top module: `mw_mem_slave`

## Requirements
- R1: While selected, serial bits of value 0 that arrive before the first 1 are discarded. The first 1 is the start bit, and the opcode begins with the next bit.
- R2: The two opcode bits, first bit first, decode as follows: 10 read, 01 write, 11 erase, and 00 the special group. In the special group, the first two address bits select the operation: 11 enables programming, 00 disables it, 10 erases everything and 01 writes everything. The remaining address bits are ignored.
- R3: With `org16_i`=1 the address field is 10 bits and the data field 16 bits. With `org16_i`=0 they are 11 and 8 bits. The first address bit is a don't-care in both cases, so the effective address is the low 9 or 10 bits. Byte address a maps to word a>>1, and a[0]=1 selects the upper half.
- R4: A read drives `dout_oe_o` high on the rising clock that samples the last address bit, with a 0 dummy bit. Each following rising clock then presents the next bit of the addressed word, most significant bit first.
- R5: While select stays high, the word after the last bit is the next address, with no dummy bit. The address wraps from 511 (16-bit mode) or 1023 (8-bit mode) to 0.
- R6: After reset, programming is disabled. A write-class frame received while disabled produces no command and leaves the array unchanged. Reads work in either state.
- R7: A write-class frame commits only if select falls before any further rising serial clock after its last bit. A frame given an extra clock is dropped.
- R8: Lowering select at any time drops `dout_oe_o` and returns to idle without a command. After reset, `dout_oe_o` and `cmd_valid_o` are 0.
- R9: A committed frame gives a one-cycle `cmd_valid_o`. `cmd_op_o` is 0 for write, 1 for erase, 2 for write-all and 3 for erase-all. It comes with the effective address and the data in the low bits. Erasing sets bits to 1, and write-all in 8-bit mode fills every byte.
- R10: After a commit, the next selection drives `dout_oe_o`=1 with `dout_o` equal to the inverse of `seq_busy_i` until a start bit is received. That start bit returns the line to high impedance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| org16_i | input | 1 | Static word size: 1 = 16-bit words, 0 = 8-bit words |
| cs_i | input | 1 | Chip select, active high, asynchronous |
| sck_i | input | 1 | Serial clock, asynchronous |
| din_i | input | 1 | Serial data in, sampled on serial clock rise |
| seq_busy_i | input | 1 | Busy flag from the programming sequencer |
| dout_o | output | 1 | Serial data out value |
| dout_oe_o | output | 1 | Output enable for dout_o (0 = high impedance) |
| cmd_valid_o | output | 1 | One-cycle pulse for a committed programming command |
| cmd_op_o | output | 2 | Command kind: 0 write, 1 erase, 2 write-all, 3 erase-all |
| cmd_addr_o | output | 10 | Effective word or byte address of the command |
| cmd_data_o | output | 16 | Data of the command (low 8 bits in 8-bit mode) |

## Verification
Each result of this block leaves its flops on the third system clock edge after the input edge that causes it. That edge may be a serial clock rise, a select edge or a busy change, because two synchronizer stages and one output register lie on every path. The bench's behavioural model updates its expected state at the instant it drives an input. It delays that expectation through a three-stage queue and compares all outputs against the delayed value in the middle of every system clock. This covers the dummy bit, the streamed words and the one-cycle command pulse on exactly the cycles they are due.

// File: rtl/mw_pkg.sv
package mw_pkg;
    typedef enum logic [2:0] {
        ST_IDLE, ST_OPC, ST_ADDR, ST_DATA, ST_DONE, ST_READ, ST_DEAD
    } fsm_e;

    localparam logic [1:0] OP_SPECIAL = 2'b00;
    localparam logic [1:0] OP_WRITE   = 2'b01;
    localparam logic [1:0] OP_READ    = 2'b10;
    localparam logic [1:0] OP_ERASE   = 2'b11;

    localparam logic [1:0] SUB_DIS    = 2'b00;
    localparam logic [1:0] SUB_WRALL  = 2'b01;
    localparam logic [1:0] SUB_ERALL  = 2'b10;
    localparam logic [1:0] SUB_EN     = 2'b11;

    localparam logic [1:0] CMD_WRITE  = 2'd0;
    localparam logic [1:0] CMD_ERASE  = 2'd1;
    localparam logic [1:0] CMD_WRALL  = 2'd2;
    localparam logic [1:0] CMD_ERALL  = 2'd3;
endpackage

// File: rtl/mw_sync.sv
module mw_sync #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] a_i,
    output logic [N-1:0] s_o
);
    typedef struct packed {
        logic [N-1:0] meta;
        logic [N-1:0] sync;
    } sync_t;

    sync_t q, d;

    // one independent two-stage chain per input bit
    for (genvar i = 0; i < N; i++) begin : g_bit
        always_comb begin
            d.meta[i] = a_i[i];
            d.sync[i] = q.meta[i];
        end
        assign s_o[i] = q.sync[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end
endmodule

// File: rtl/mw_array.sv
module mw_array #(
    parameter int WORD_AW = 9,
    parameter int WORD_W  = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 org16_i,
    input  logic                 we_i,
    input  logic [1:0]           op_i,
    input  logic [WORD_AW:0]     addr_i,
    input  logic [WORD_W-1:0]    data_i,
    input  logic [WORD_AW:0]     rd_addr_i,
    output logic [WORD_W-1:0]    rd_data_o
);
    import mw_pkg::*;
    localparam int DEPTH  = 1 << WORD_AW;
    localparam int BAW    = WORD_AW + 1;
    localparam int BYTE_W = WORD_W / 2;

    logic [WORD_W-1:0]  mem_q [DEPTH];
    logic [WORD_W-1:0]  mem_d [DEPTH];
    logic [WORD_W-1:0]  fill;
    logic [WORD_AW-1:0] wsel;
    logic [WORD_AW-1:0] rsel;
    logic [WORD_W-1:0]  rword;
    logic               all_op;

    always_comb begin
        if (op_i == CMD_ERASE || op_i == CMD_ERALL) fill = '1;
        else if (org16_i)                           fill = data_i;
        else fill = {data_i[BYTE_W-1:0], data_i[BYTE_W-1:0]};
        wsel   = org16_i ? addr_i[WORD_AW-1:0] : addr_i[BAW-1:1];
        all_op = (op_i == CMD_WRALL) || (op_i == CMD_ERALL);
        for (int i = 0; i < DEPTH; i++) begin
            mem_d[i] = mem_q[i];
            if (we_i) begin
                if (all_op) begin
                    mem_d[i] = fill;
                end else if (wsel == WORD_AW'(i)) begin
                    if (org16_i)        mem_d[i] = fill;
                    else if (addr_i[0]) mem_d[i] = {fill[WORD_W-1:BYTE_W], mem_q[i][BYTE_W-1:0]};
                    else                mem_d[i] = {mem_q[i][WORD_W-1:BYTE_W], fill[BYTE_W-1:0]};
                end
            end
        end
    end

    always_comb begin
        rsel  = org16_i ? rd_addr_i[WORD_AW-1:0] : rd_addr_i[BAW-1:1];
        rword = mem_q[rsel];
        if (org16_i)          rd_data_o = rword;
        else if (rd_addr_i[0]) rd_data_o = {{BYTE_W{1'b0}}, rword[WORD_W-1:BYTE_W]};
        else                   rd_data_o = {{BYTE_W{1'b0}}, rword[BYTE_W-1:0]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '1;
        end else begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= mem_d[i];
        end
    end

    // R9
    erall_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && op_i == CMD_ERALL) |=> (mem_q[0] == '1 && mem_q[DEPTH-1] == '1));
endmodule

// File: rtl/mw_frame.sv
module mw_frame #(
    parameter int WORD_AW = 9,
    parameter int WORD_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              org16_i,
    input  logic              cs_i,
    input  logic              sck_i,
    input  logic              din_i,
    input  logic              busy_i,
    input  logic [WORD_W-1:0] rd_data_i,
    output logic [WORD_AW:0]  rd_addr_o,
    output logic              dout_o,
    output logic              oe_o,
    output logic              cmd_valid_o,
    output logic [1:0]        cmd_op_o,
    output logic [WORD_AW:0]  cmd_addr_o,
    output logic [WORD_W-1:0] cmd_data_o
);
    import mw_pkg::*;
    localparam int BAW    = WORD_AW + 1;
    localparam int AF16   = WORD_AW + 1;
    localparam int AF8    = WORD_AW + 2;
    localparam int BYTE_W = WORD_W / 2;
    localparam int MAXLEN = (WORD_W > AF8) ? WORD_W : AF8;
    localparam int CW     = $clog2(MAXLEN);

    typedef struct packed {
        fsm_e              st;
        logic              sck_p;
        logic              cs_p;
        logic [CW-1:0]     cnt;
        logic [1:0]        op;
        logic [AF8-1:0]    af;
        logic [WORD_W-1:0] dat;
        logic [BAW-1:0]    raddr;
        logic [CW-1:0]     bpos;
        logic              wen;
        logic              status;
        logic              oe;
        logic              dout;
        logic              cv;
        logic [1:0]        cop;
        logic [BAW-1:0]    caddr;
    } frame_t;

    frame_t q, d;

    logic              sck_rise, cs_fall;
    logic [CW-1:0]     alen_m1, dlen_m1;
    logic [AF8-1:0]    af_sh;
    logic [WORD_W-1:0] dat_sh;
    logic [BAW-1:0]    eff_addr, raddr_inc;
    logic [1:0]        sub;

    always_comb begin
        sck_rise  = sck_i & ~q.sck_p;
        cs_fall   = q.cs_p & ~cs_i;
        alen_m1   = org16_i ? CW'(AF16 - 1) : CW'(AF8 - 1);
        dlen_m1   = org16_i ? CW'(WORD_W - 1) : CW'(BYTE_W - 1);
        af_sh     = {q.af[AF8-2:0], din_i};
        dat_sh    = {q.dat[WORD_W-2:0], din_i};
        eff_addr  = org16_i ? {1'b0, af_sh[WORD_AW-1:0]} : af_sh[BAW-1:0];
        sub       = org16_i ? af_sh[AF16-1 -: 2] : af_sh[AF8-1 -: 2];
        raddr_inc = org16_i ? {1'b0, q.raddr[WORD_AW-1:0] + 1'b1} : q.raddr + 1'b1;

        d       = q;
        d.sck_p = sck_i;
        d.cs_p  = cs_i;
        d.cv    = 1'b0;

        if (!cs_i) begin
            if (cs_fall && q.st == ST_DONE && q.wen) begin
                d.cv     = 1'b1;
                d.status = 1'b1;
            end
            d.st   = ST_IDLE;
            d.oe   = 1'b0;
            d.dout = 1'b0;
        end else begin
            if (q.st == ST_IDLE && q.status) begin
                d.oe   = 1'b1;
                d.dout = ~busy_i;
            end
            if (sck_rise) begin
                unique case (q.st)
                    ST_IDLE: begin
                        if (din_i) begin
                            d.st     = ST_OPC;
                            d.cnt    = '0;
                            d.status = 1'b0;
                            d.oe     = 1'b0;
                            d.dout   = 1'b0;
                            d.dat    = '0;
                        end
                    end
                    ST_OPC: begin
                        d.op = {q.op[0], din_i};
                        if (q.cnt == CW'(1)) begin
                            d.st  = ST_ADDR;
                            d.cnt = '0;
                        end else begin
                            d.cnt = q.cnt + 1'b1;
                        end
                    end
                    ST_ADDR: begin
                        d.af = af_sh;
                        if (q.cnt == alen_m1) begin
                            d.cnt   = '0;
                            d.caddr = eff_addr;
                            unique case (q.op)
                                OP_READ: begin
                                    d.st    = ST_READ;
                                    d.raddr = eff_addr;
                                    d.bpos  = dlen_m1;
                                    d.oe    = 1'b1;
                                    d.dout  = 1'b0;
                                end
                                OP_WRITE: begin
                                    d.cop = CMD_WRITE;
                                    d.st  = ST_DATA;
                                end
                                OP_ERASE: begin
                                    d.cop = CMD_ERASE;
                                    d.st  = ST_DONE;
                                end
                                default: begin
                                    unique case (sub)
                                        SUB_EN:    begin d.wen = 1'b1; d.st = ST_DEAD; end
                                        SUB_DIS:   begin d.wen = 1'b0; d.st = ST_DEAD; end
                                        SUB_ERALL: begin d.cop = CMD_ERALL; d.st = ST_DONE; end
                                        default:   begin d.cop = CMD_WRALL; d.st = ST_DATA; end
                                    endcase
                                end
                            endcase
                        end else begin
                            d.cnt = q.cnt + 1'b1;
                        end
                    end
                    ST_DATA: begin
                        d.dat = dat_sh;
                        if (q.cnt == dlen_m1) d.st = ST_DONE;
                        else                  d.cnt = q.cnt + 1'b1;
                    end
                    ST_DONE: d.st = ST_DEAD;
                    ST_READ: begin
                        d.dout = rd_data_i[q.bpos];
                        if (q.bpos == '0) begin
                            d.bpos  = dlen_m1;
                            d.raddr = raddr_inc;
                        end else begin
                            d.bpos = q.bpos - 1'b1;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    assign rd_addr_o   = q.raddr;
    assign dout_o      = q.dout;
    assign oe_o        = q.oe;
    assign cmd_valid_o = q.cv;
    assign cmd_op_o    = q.cop;
    assign cmd_addr_o  = q.caddr;
    assign cmd_data_o  = q.dat;

    // R8
    desel_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_i |=> !q.oe);
    // R6
    cmd_needs_wen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.cv |-> $past(q.wen));
    // R7
    cmd_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.cv |-> $past(q.st) == ST_DONE);
    // R9
    cmd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.cv |=> !q.cv);
    // R4
    dummy_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_READ && $past(q.st) != ST_READ) |-> (q.oe && !q.dout));
endmodule

// File: rtl/mw_mem_slave.sv
module mw_mem_slave #(
    parameter int WORD_AW = 9,
    parameter int WORD_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              org16_i,
    input  logic              cs_i,
    input  logic              sck_i,
    input  logic              din_i,
    input  logic              seq_busy_i,
    output logic              dout_o,
    output logic              dout_oe_o,
    output logic              cmd_valid_o,
    output logic [1:0]        cmd_op_o,
    output logic [WORD_AW:0]  cmd_addr_o,
    output logic [WORD_W-1:0] cmd_data_o
);
    localparam int NSYNC = 4;

    logic [NSYNC-1:0]  raw, syn;
    logic [WORD_AW:0]  rd_addr;
    logic [WORD_W-1:0] rd_data;

    assign raw = {seq_busy_i, din_i, sck_i, cs_i};

    mw_sync #(.N(NSYNC)) u_sync (
        .clk(clk), .rst_n(rst_n), .a_i(raw), .s_o(syn)
    );

    mw_frame #(.WORD_AW(WORD_AW), .WORD_W(WORD_W)) u_frame (
        .clk(clk), .rst_n(rst_n), .org16_i(org16_i),
        .cs_i(syn[0]), .sck_i(syn[1]), .din_i(syn[2]), .busy_i(syn[3]),
        .rd_data_i(rd_data), .rd_addr_o(rd_addr),
        .dout_o(dout_o), .oe_o(dout_oe_o),
        .cmd_valid_o(cmd_valid_o), .cmd_op_o(cmd_op_o),
        .cmd_addr_o(cmd_addr_o), .cmd_data_o(cmd_data_o)
    );

    mw_array #(.WORD_AW(WORD_AW), .WORD_W(WORD_W)) u_array (
        .clk(clk), .rst_n(rst_n), .org16_i(org16_i),
        .we_i(cmd_valid_o), .op_i(cmd_op_o), .addr_i(cmd_addr_o),
        .data_i(cmd_data_o), .rd_addr_i(rd_addr), .rd_data_o(rd_data)
    );
endmodule

// File: tb/sim_mw_mem_slave.sv
module sim_mw_mem_slave;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 4;
    localparam int WDOG       = 150000;

    logic clk = 1'b0, rst_n = 1'b0, org16 = 1'b1;
    logic cs = 1'b0, sck = 1'b0, din = 1'b0, busy = 1'b0;
    logic        dout, dout_oe, cmd_valid;
    logic [1:0]  cmd_op;
    logic [9:0]  cmd_addr;
    logic [15:0] cmd_data;

    mw_mem_slave u0 (
        .clk(clk), .rst_n(rst_n), .org16_i(org16), .cs_i(cs), .sck_i(sck),
        .din_i(din), .seq_busy_i(busy), .dout_o(dout), .dout_oe_o(dout_oe),
        .cmd_valid_o(cmd_valid), .cmd_op_o(cmd_op), .cmd_addr_o(cmd_addr),
        .cmd_data_o(cmd_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct packed {
        logic        oe, dout, cv, cmp_addr, cmp_data;
        logic [1:0]  op;
        logic [9:0]  addr;
        logic [15:0] data;
    } exp_t;

    localparam int P_IDLE = 0, P_COL = 1, P_DONE = 2, P_READ = 3, P_DEAD = 4;

    logic [7:0] mem_m [1024];
    int   ph, raddr_m, bpos_m, kind_m, caddr_m, data_m;
    bit   wen_m, stat_m, cs_m, roe_m, rdo_m, cv_m;
    bit   bits_q [$];
    exp_t pipe [3];
    int   total = 0, bad = 0, cyc = 0;
    bit   done = 0;
    string cur_req = "R8";

    function automatic int wbits();  return org16 ? 16 : 8;    endfunction
    function automatic int abits();  return org16 ? 10 : 11;   endfunction
    function automatic int depth();  return org16 ? 512 : 1024; endfunction
    function automatic int getword(int a);
        if (org16) return {mem_m[2*a+1], mem_m[2*a]};
        return int'(mem_m[a]);
    endfunction

    task automatic model_reset();
        for (int i = 0; i < 1024; i++) mem_m[i] = 8'hFF;
        ph = P_IDLE; wen_m = 0; stat_m = 0; cs_m = 0; roe_m = 0; rdo_m = 0; cv_m = 0;
        bits_q = {};
    endtask

    task automatic model_commit();
        cv_m = 1; stat_m = 1;
        case (kind_m)
            0: if (org16) begin
                   mem_m[2*caddr_m] = data_m[7:0]; mem_m[2*caddr_m+1] = data_m[15:8];
               end else mem_m[caddr_m] = data_m[7:0];
            1: if (org16) begin
                   mem_m[2*caddr_m] = 8'hFF; mem_m[2*caddr_m+1] = 8'hFF;
               end else mem_m[caddr_m] = 8'hFF;
            2: for (int i = 0; i < 1024; i++)
                   mem_m[i] = (org16 && i % 2 == 1) ? data_m[15:8] : data_m[7:0];
            default: for (int i = 0; i < 1024; i++) mem_m[i] = 8'hFF;
        endcase
    endtask

    task automatic model_cs(bit v);
        if (!v && cs_m) begin
            if (ph == P_DONE && wen_m) model_commit();
            ph = P_IDLE; roe_m = 0; rdo_m = 0;
        end
        cs_m = v;
    endtask

    task automatic model_rise(bit b);
        int n, a, op, sub;
        if (!cs_m) return;
        case (ph)
            P_IDLE: if (b) begin ph = P_COL; bits_q = {}; stat_m = 0; end
            P_COL: begin
                bits_q.push_back(b);
                n = bits_q.size();
                if (n == 2 + abits()) begin
                    op = bits_q[0] * 2 + bits_q[1];
                    a = 0;
                    for (int i = 0; i < abits(); i++) a = a * 2 + bits_q[2+i];
                    caddr_m = a % depth();
                    case (op)
                        2: begin ph = P_READ; roe_m = 1; rdo_m = 0; raddr_m = caddr_m; bpos_m = wbits() - 1; end
                        1: kind_m = 0;
                        3: begin kind_m = 1; ph = P_DONE; end
                        default: begin
                            sub = bits_q[2] * 2 + bits_q[3];
                            case (sub)
                                3: begin wen_m = 1; ph = P_DEAD; end
                                0: begin wen_m = 0; ph = P_DEAD; end
                                2: begin kind_m = 3; ph = P_DONE; end
                                default: kind_m = 2;
                            endcase
                        end
                    endcase
                end else if (n == 2 + abits() + wbits()) begin
                    data_m = 0;
                    for (int i = 0; i < wbits(); i++) data_m = data_m * 2 + bits_q[2+abits()+i];
                    ph = P_DONE;
                end
            end
            P_DONE: ph = P_DEAD;
            P_READ: begin
                rdo_m = getword(raddr_m)[bpos_m];
                if (bpos_m == 0) begin
                    bpos_m = wbits() - 1;
                    raddr_m = (raddr_m + 1) % depth();
                end else bpos_m--;
            end
            default: ;
        endcase
    endtask

    function automatic exp_t cur_exp();
        exp_t e;
        bit st;
        e = '0;
        st = cs_m && stat_m && ph == P_IDLE;
        e.oe = roe_m | st;
        e.dout = roe_m ? rdo_m : (st ? ~busy : 1'b0);
        e.cv = cv_m;
        e.op = kind_m[1:0];
        e.addr = caddr_m[9:0];
        e.data = data_m[15:0];
        e.cmp_addr = (kind_m < 2);
        e.cmp_data = (kind_m == 0 || kind_m == 2);
        return e;
    endfunction

    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            pipe[0] = '0; pipe[1] = '0; pipe[2] = '0;
        end else begin
            pipe[2] = pipe[1]; pipe[1] = pipe[0]; pipe[0] = cur_exp();
            cv_m = 0;
        end
        if (cyc > WDOG && !done) begin
            done = 1; total++; bad++;
            $display("FAIL watchdog %s act=%0d exp=%0d", cur_req, cyc, WDOG);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic chk(bit ok, string what, int act, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s act=%0h exp=%0h t=%0t", cur_req, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(dout_oe == pipe[2].oe, "dout_oe", dout_oe, pipe[2].oe);
            if (pipe[2].oe) chk(dout == pipe[2].dout, "dout", dout, pipe[2].dout);
            chk(cmd_valid == pipe[2].cv, "cmd_valid", cmd_valid, pipe[2].cv);
            if (pipe[2].cv) begin
                chk(cmd_op == pipe[2].op, "cmd_op", cmd_op, pipe[2].op);
                if (pipe[2].cmp_addr) chk(cmd_addr == pipe[2].addr, "cmd_addr", cmd_addr, pipe[2].addr);
                if (pipe[2].cmp_data) begin
                    if (org16) chk(cmd_data == pipe[2].data, "cmd_data", cmd_data, pipe[2].data);
                    else chk(cmd_data[7:0] == pipe[2].data[7:0], "cmd_data", cmd_data[7:0], pipe[2].data[7:0]);
                end
            end
        end
    end

    task automatic tick(int n); repeat (n) @(negedge clk); endtask
    task automatic set_cs(bit v); cs = v; model_cs(v); tick(HALF); endtask
    task automatic sbit(bit b);
        din = b; tick(HALF);
        sck = 1'b1; model_rise(b); tick(HALF);
        sck = 1'b0;
    endtask
    task automatic sbits(int v, int n);
        for (int i = n - 1; i >= 0; i--) sbit(v[i]);
    endtask
    task automatic send_cmd(int op, int a);
        sbit(1'b1); sbits(op, 2); sbits(a, abits());
    endtask
    task automatic wr(int a, int dv, int lead = 0, int extra = 0);
        set_cs(1);
        repeat (lead) sbit(1'b0);
        send_cmd(1, a); sbits(dv, wbits());
        repeat (extra) sbit(1'b0);
        set_cs(0);
    endtask
    task automatic special(int sub, int dv = 0, bit has_data = 0);
        set_cs(1); send_cmd(0, sub << (abits() - 2));
        if (has_data) sbits(dv, wbits());
        set_cs(0);
    endtask
    task automatic rd(int a, int nbits);
        set_cs(1); send_cmd(2, a); repeat (nbits) sbit(1'b0); set_cs(0);
    endtask
    task automatic do_reset(bit o16);
        rst_n = 1'b0; org16 = o16; model_reset(); tick(4);
        rst_n = 1'b1; tick(3);
    endtask

    initial begin
        @(negedge clk);
        do_reset(1'b1);
        cur_req = "R8";
        chk(dout_oe == 1'b0, "reset dout_oe", dout_oe, 0);
        chk(cmd_valid == 1'b0, "reset cmd_valid", cmd_valid, 0);

        cur_req = "R6"; wr(5, 16'h1234); rd(5, 16);
        cur_req = "R2"; special(3);
        cur_req = "R1"; wr(5, 16'hA5C3, 3);
        cur_req = "R10";
        busy = 1'b1; set_cs(1); tick(10); busy = 1'b0; tick(10);
        send_cmd(2, 5); repeat (16) sbit(1'b0); set_cs(0);
        cur_req = "R9"; wr(511, 16'hBEEF); wr(0, 16'h0F0F); wr(510, 16'h8001);
        cur_req = "R5"; rd(510, 48);
        cur_req = "R4"; rd(0, 20);
        cur_req = "R3"; wr(10'h200 | 7, 16'hC3A5); rd(7, 16);
        cur_req = "R7"; wr(9, 16'h5555, 0, 1); rd(9, 16);
        cur_req = "R8";
        set_cs(1); send_cmd(2, 7); repeat (5) sbit(1'b0); set_cs(0); tick(4);
        chk(dout_oe == 1'b0, "abort read oe", dout_oe, 0);
        set_cs(1); send_cmd(1, 7); sbits(4'hA, 4); set_cs(0); rd(7, 16);
        cur_req = "R9";
        set_cs(1); send_cmd(3, 7); set_cs(0); rd(7, 16);
        special(1, 16'h1234, 1); rd(100, 32);
        special(2); rd(300, 16);
        cur_req = "R6"; special(0); wr(3, 16'h7777); rd(3, 16);

        do_reset(1'b0);
        cur_req = "R3"; special(3);
        wr(11'h7FF, 8'h5A); wr(0, 8'hC3); wr(1, 8'h99); rd(1, 8);
        cur_req = "R5"; rd(1023, 24);
        cur_req = "R9"; special(1, 8'h3C, 1); rd(517, 16);
        set_cs(1); send_cmd(3, 11'h400 | 2); set_cs(0); rd(1, 16);
        tick(10);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule